// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-side controller of a serial memory that sits on a two-wire I2C bus as a slave. It conditions the SCL and SDA inputs with synchronizers and a majority filter, and it finds START, repeated START and STOP conditions. It decodes the device-select byte against a fixed four-bit prefix and three strap inputs. After a write-mode select it collects a two-byte word address. It acknowledges by asserting an open-drain output-enable that pulls SDA low.

The memory array sits behind a byte-level event interface. The front end announces a new word address, delivers each written byte, and tells the array when a write transaction has closed with a STOP. On reads it takes the byte the array presents, consumes it, and shifts it out MSB first. It reports each master ACK or NACK. A busy input from the array's programming timer makes the block ignore its own select. A write-protect input, captured once per transaction, makes it refuse the first data byte.

Top module: `i2c_fe_top`

## Requirements
- R1: After reset `sda_oe` is 0 and no event output pulses until a START is seen.
- R2: A select byte whose bits 7:4 are 1010 and whose bits 3:1 equal `strap_i[2:0]` is acknowledged: SDA is held low for the whole high time of the ninth SCL pulse. Bit 0 selects read (1) or write (0).
- R3: A select byte with any other prefix or strap value gets no acknowledge, and `sda_oe` stays 0 for the rest of the transaction until the next START.
- R4: While `busy_i` is 1 the block does not acknowledge even a matching select byte.
- R5: After a write select, two address bytes follow, high byte first, and both are acknowledged. `addr_load` pulses once with `word_addr` = {high byte bits 3:0, low byte}. High byte bits 7:4 are ignored.
- R6: Every data byte after the word address is acknowledged, and each one produces one `wr_stb` pulse with the byte on `wr_data`.
- R7: `wp_i` is captured at the end of the acknowledge slot of the low address byte. When it is 1, both address bytes are still acknowledged, the first data byte is not, no `wr_stb` occurs, and SDA stays released until the next START.
- R8: `commit` pulses on a STOP only when the transaction delivered at least one written byte. A STOP without data, or a repeated START before the STOP, gives no `commit`.
- R9: On a read select the block pulses `rd_take` and drives `rd_data` MSB first. `sda_oe` changes only while SCL is low.
- R10: In the ninth slot of a read byte, a master ACK (SDA low) pulses `mack_evt` and starts the next byte from a new `rd_take`. A NACK pulses `mnack_evt` and releases SDA until the next START.
- R11: A repeated START after the word address, followed by a read select, returns the byte at that word address (a random read).
- R12: A START or STOP at any bit position aborts the current byte without any event. After a STOP the block waits for a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 3 | Device-select strap value |
| wp_i | input | 1 | Write-protect level |
| busy_i | input | 1 | Array is programming; ignore select |
| addr_load | output | 1 | Pulse: new word address valid |
| word_addr | output | WA_W | Word address from the two address bytes |
| wr_stb | output | 1 | Pulse: one data byte received |
| wr_data | output | 8 | Received data byte |
| commit | output | 1 | Pulse: write transaction closed by STOP |
| rd_data | input | 8 | Byte at the array's current pointer |
| rd_take | output | 1 | Pulse: `rd_data` latched, advance pointer |
| mack_evt | output | 1 | Pulse: master acknowledged a read byte |
| mnack_evt | output | 1 | Pulse: master did not acknowledge |

## Verification
The bench sweeps every strap value against every select value and against every wrong prefix. A decoder that compared the strap bits in the wrong order, or ignored the prefix, would acknowledge devices other than its own. Write protection and busy are tested at the ports: if the capture point were wrong, or busy were ignored, writes would land in the array or polls would be acknowledged. Reads cross the top of the address range and end in a NACK. STOPs and repeated STARTs are placed in the middle of a byte and after a byte without data, to catch spurious `commit` pulses, stray events, and an SDA line left held low.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } fe_st_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         BYTE_W     = 8;

  // true when a select byte addresses this device
  function automatic logic dev_hit(input logic [7:0] sel, input logic [2:0] strap);
    return (sel[7:4] == DEV_PREFIX) && (sel[3:1] == strap);
  endfunction

endpackage

// File: rtl/i2c_fe_sync.sv
module i2c_fe_sync #(
  parameter int   STAGES  = 2,
  parameter int   TAPS    = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] meta;
  logic [TAPS-1:0]   win;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= {STAGES{RST_VAL}};
      win  <= {TAPS{RST_VAL}};
      q    <= RST_VAL;
    end else begin
      meta <= {meta[STAGES-2:0], d};
      win  <= {win[TAPS-2:0], meta[STAGES-1]};
      q    <= ($countones(win) > (TAPS / 2));
    end
  end

endmodule

// File: rtl/i2c_fe_edge.sv
module i2c_fe_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      start_c  <= 1'b0;
      stop_c   <= 1'b0;
    end else begin
      scl_q    <= scl;
      sda_q    <= sda;
      scl_rise <= scl & ~scl_q;
      scl_fall <= ~scl & scl_q;
      start_c  <= scl & scl_q & sda_q & ~sda;
      stop_c   <= scl & scl_q & ~sda_q & sda;
    end
  end

endmodule

// File: rtl/i2c_fe_top.sv
module i2c_fe_top
  import i2c_fe_pkg::*;
#(
  parameter int WA_W        = 12,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              addr_load,
  output logic [WA_W-1:0]   word_addr,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_take,
  output logic              mack_evt,
  output logic              mnack_evt
);

  localparam int HI_BITS = WA_W - BYTE_W;
  localparam int NLINES  = 3;
  localparam logic [3:0] ACK_SLOT  = 4'd8;
  localparam logic [3:0] POST_SLOT = 4'd9;

  // line 0 = SDA, line 1 = SCL, line 2 = write protect
  logic [NLINES-1:0] raw, filt;
  assign raw = {wp_i, scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_fe_sync #(
      .STAGES (SYNC_STAGES),
      .TAPS   (FILT_TAPS),
      .RST_VAL((g == 2) ? 1'b0 : 1'b1)
    ) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (raw[g]),
      .q  (filt[g])
    );
  end

  logic sda_f, scl_f, wp_f;
  assign sda_f = filt[0];
  assign scl_f = filt[1];
  assign wp_f  = filt[2];

  logic scl_rise, scl_fall, start_c, stop_c;

  i2c_fe_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .scl     (scl_f),
    .sda     (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c)
  );

  fe_st_e             st;
  logic [3:0]         cnt;
  logic [BYTE_W-1:0]  rsr;
  logic [BYTE_W-1:0]  tsr;
  logic [HI_BITS-1:0] ahi;
  logic               rw;
  logic               wp_lat;
  logic               wrote;
  logic               mack;
  logic [2:0]         bit_idx;

  assign bit_idx = 3'd7 - cnt[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rsr       <= '0;
      tsr       <= '0;
      ahi       <= '0;
      rw        <= 1'b0;
      wp_lat    <= 1'b0;
      wrote     <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      addr_load <= 1'b0;
      word_addr <= '0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
      commit    <= 1'b0;
      rd_take   <= 1'b0;
      mack_evt  <= 1'b0;
      mnack_evt <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      wr_stb    <= 1'b0;
      commit    <= 1'b0;
      rd_take   <= 1'b0;
      mack_evt  <= 1'b0;
      mnack_evt <= 1'b0;

      if (start_c) begin
        st     <= ST_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        commit <= wrote;
        wrote  <= 1'b0;
      end else if (st == ST_IDLE || st == ST_SKIP) begin
        cnt <= '0;
      end else if (scl_rise) begin
        if (cnt < ACK_SLOT) begin
          rsr <= {rsr[BYTE_W-2:0], sda_f};
          cnt <= cnt + 4'd1;
        end else if (cnt == ACK_SLOT) begin
          cnt <= POST_SLOT;
          if (st == ST_RDAT) begin
            mack      <= ~sda_f;
            mack_evt  <= ~sda_f;
            mnack_evt <= sda_f;
          end
        end
      end else if (scl_fall) begin
        if (cnt == ACK_SLOT) begin
          // eight bits are in: decide the acknowledge, or release for the master's
          case (st)
            ST_DEV: begin
              sda_oe <= dev_hit(rsr, strap_i) && !busy_i;
              rw     <= rsr[0];
            end
            ST_AHI: begin
              sda_oe <= 1'b1;
              ahi    <= rsr[HI_BITS-1:0];
            end
            ST_ALO: begin
              sda_oe    <= 1'b1;
              addr_load <= 1'b1;
              word_addr <= {ahi, rsr};
            end
            ST_WDAT: begin
              sda_oe  <= !wp_lat;
              wr_stb  <= !wp_lat;
              wr_data <= rsr;
              if (!wp_lat) wrote <= 1'b1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (cnt == POST_SLOT) begin
          cnt    <= '0;
          sda_oe <= 1'b0;
          case (st)
            ST_DEV: begin
              if (!sda_oe) begin
                st <= ST_SKIP;
              end else if (rw) begin
                st      <= ST_RDAT;
                tsr     <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                rd_take <= 1'b1;
              end else begin
                st <= ST_AHI;
              end
            end
            ST_AHI: st <= ST_ALO;
            ST_ALO: begin
              st     <= ST_WDAT;
              wp_lat <= wp_f;
            end
            ST_WDAT: if (!sda_oe) st <= ST_SKIP;
            ST_RDAT: begin
              if (mack) begin
                tsr     <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                rd_take <= 1'b1;
              end else begin
                st <= ST_SKIP;
              end
            end
            default: st <= ST_SKIP;
          endcase
        end else if (st == ST_RDAT && cnt != 4'd0) begin
          sda_oe <= ~tsr[bit_idx];
        end
      end
    end
  end

  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> !sda_oe);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);

  // R9
  oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));

  // R6
  evt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({addr_load, wr_stb, rd_take, commit}));

  // R10
  mack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mack_evt && mnack_evt));

  // R8
  commit_stop_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(stop_c));

  // R5
  load_phase_chk: assert property (@(posedge clk) disable iff (rst)
    addr_load |-> $past(st == ST_ALO));

  // R12
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= POST_SLOT);

endmodule

// File: tb/sim_i2c_fe_top.sv
`timescale 1ns/1ps
module sim_i2c_fe_top;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [2:0]  strap = 3'd0;
  logic        wp = 1'b0;
  logic        busy = 1'b0;
  logic        sda_oe, addr_load, wr_stb, commit, rd_take, mack_evt, mnack_evt;
  logic [11:0] word_addr;
  logic [7:0]  wr_data, rd_data;
  logic        sda_line;

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_fe_top u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .wp_i(wp), .busy_i(busy), .addr_load(addr_load),
    .word_addr(word_addr), .wr_stb(wr_stb), .wr_data(wr_data), .commit(commit),
    .rd_data(rd_data), .rd_take(rd_take), .mack_evt(mack_evt), .mnack_evt(mnack_evt)
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    return 8'((a * 29) + 7);
  endfunction

  // array model behind the event interface, updated away from the active edge
  logic [7:0]  mem [256];
  logic [11:0] ptr;
  int n_load = 0, n_wr = 0, n_commit = 0, n_take = 0, n_mack = 0, n_mnack = 0;
  int oe_cyc = 0, glitch = 0;
  logic [7:0] last_wr;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  assign rd_data = mem[ptr[7:0]];

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
      ptr <= '0;
    end else begin
      if (addr_load) begin ptr <= word_addr; n_load <= n_load + 1; end
      if (wr_stb) begin
        mem[ptr[7:0]] <= wr_data;
        ptr <= {ptr[11:5], ptr[4:0] + 5'd1};
        n_wr <= n_wr + 1;
        last_wr <= wr_data;
      end
      if (rd_take) begin ptr <= ptr + 12'd1; n_take <= n_take + 1; end
      if (commit) n_commit <= n_commit + 1;
      if (mack_evt) n_mack <= n_mack + 1;
      if (mnack_evt) n_mnack <= n_mnack + 1;
      if (sda_oe) oe_cyc <= oe_cyc + 1;
      if (m_scl && prev_scl && (sda_oe != prev_oe)) glitch <= glitch + 1;
      prev_scl <= m_scl;
      prev_oe  <= sda_oe;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    put_bits(b, 8);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(2);
    a1 = sda_line; tick(2 * Q - 4);
    a2 = sda_line; tick(2);
    m_scl = 1'b0; tick(Q);
    ack = !a1 && !a2;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = !give_ack; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, output logic ok);
    logic a0, a1, a2;
    bus_start();
    wbyte({4'b1010, strap, 1'b0}, a0);
    wbyte(hi, a1);
    wbyte(lo, a2);
    ok = a0 && a1 && a2;
  endtask

  initial begin
    logic ack, ok;
    logic [7:0] rb;
    int base, oe0;
    tick(10);
    rst = 1'b0;
    tick(5);

    // R1 reset state
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 events after reset", n_load + n_wr + n_commit + n_take, 0);

    // R2 / R3 strap sweep
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        wbyte({4'b1010, 3'(a), 1'b0}, ack);
        chk($sformatf("R2 select strap=%0d addr=%0d", s, a), ack, (a == s));
        if (!ack) begin
          oe0 = oe_cyc;
          wbyte(8'h00, ack);
          chk("R3 silent after mismatch", oe_cyc - oe0, 0);
        end
        bus_stop();
      end
    end

    // R3 wrong prefixes
    strap = 3'd5;
    for (int p = 0; p < 16; p++) begin
      if (p != 10) begin
        bus_start();
        wbyte({4'(p), 3'd5, 1'b0}, ack);
        chk($sformatf("R3 prefix %0h", p), ack, 0);
        bus_stop();
      end
    end

    // R4 busy suppresses the select acknowledge
    busy = 1'b1;
    bus_start(); wbyte({4'b1010, 3'd5, 1'b0}, ack); bus_stop();
    chk("R4 no ack while busy", ack, 0);
    busy = 1'b0;
    bus_start(); wbyte({4'b1010, 3'd5, 1'b0}, ack); bus_stop();
    chk("R4 ack when idle", ack, 1);

    // R5 / R6 / R8 page write
    base = n_wr;
    set_addr(8'hF3, 8'h45, ok);
    chk("R5 both address bytes acked", ok, 1);
    chk("R5 word address", word_addr, 12'h345);
    wbyte(8'hA1, ack); chk("R6 data0 ack", ack, 1);
    wbyte(8'h5C, ack); chk("R6 data1 ack", ack, 1);
    wbyte(8'h0E, ack); chk("R6 data2 ack", ack, 1);
    chk("R6 write strobes", n_wr - base, 3);
    chk("R6 last data", last_wr, 8'h0E);
    base = n_commit;
    bus_stop(); tick(Q);
    chk("R8 commit after data", n_commit - base, 1);

    // R11 / R9 / R10 random read back with sequential continuation
    base = n_take;
    set_addr(8'h03, 8'h45, ok);
    bus_start();
    wbyte({4'b1010, 3'd5, 1'b1}, ack);
    chk("R11 read select ack", ack, 1);
    rbyte(1'b1, rb); chk("R11 byte at word address", rb, 8'hA1);
    rbyte(1'b1, rb); chk("R10 next after ack", rb, 8'h5C);
    rbyte(1'b0, rb); chk("R9 third byte", rb, 8'h0E);
    chk("R10 master acks", n_mack, 2);
    chk("R10 master nack", n_mnack, 1);
    chk("R9 bytes taken", n_take - base, 3);
    oe0 = oe_cyc;
    tick(4 * Q);
    bus_stop();
    chk("R10 released after nack", oe_cyc - oe0, 0);

    // R10 read across the top of the address range
    set_addr(8'h0F, 8'hFE, ok);
    bus_start(); wbyte({4'b1010, 3'd5, 1'b1}, ack);
    rbyte(1'b1, rb); chk("R10 read FFE", rb, pat(8'hFE));
    rbyte(1'b1, rb); chk("R10 read FFF", rb, pat(8'hFF));
    rbyte(1'b0, rb); chk("R10 read wrap 000", rb, pat(8'h00));
    bus_stop();

    // R7 write protect
    wp = 1'b1;
    base = n_wr;
    set_addr(8'h01, 8'h20, ok);
    chk("R7 address acked under protect", ok, 1);
    wbyte(8'h99, ack); chk("R7 first data refused", ack, 0);
    oe0 = oe_cyc;
    wbyte(8'h66, ack);
    chk("R7 silent after refusal", oe_cyc - oe0, 0);
    chk("R7 no write strobe", n_wr - base, 0);
    base = n_commit;
    bus_stop(); tick(Q);
    chk("R7 no commit", n_commit - base, 0);
    wp = 1'b0;
    set_addr(8'h01, 8'h20, ok);
    bus_start(); wbyte({4'b1010, 3'd5, 1'b1}, ack);
    rbyte(1'b0, rb); bus_stop();
    chk("R7 cell unchanged", rb, pat(8'h20));

    // R8 STOP without data, and repeated START discarding a write
    base = n_commit;
    set_addr(8'h00, 8'h10, ok); bus_stop(); tick(Q);
    chk("R8 no commit without data", n_commit - base, 0);
    set_addr(8'h00, 8'h11, ok); wbyte(8'h42, ack);
    bus_start(); bus_stop(); tick(Q);
    chk("R8 restart discards commit", n_commit - base, 0);

    // R12 STOP in the middle of a select byte
    base = n_load + n_wr + n_take;
    bus_start(); put_bits(8'hA0, 4); bus_stop(); tick(Q);
    chk("R12 no event on aborted byte", n_load + n_wr + n_take - base, 0);
    chk("R12 released after abort", sda_oe, 0);
    bus_start(); wbyte({4'b1010, 3'd5, 1'b0}, ack); bus_stop();
    chk("R12 recovers on next START", ack, 1);

    // R9 output only changes with SCL low
    chk("R9 no change while SCL high", glitch, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule